// File: doc/BRIEF.md
# Per-Lane Burst Checksum Emitter

This block guards each byte lane of a 32-bit memory data path with an 8-bit cyclic checksum. It watches the eight beats of every read or write burst and folds each lane's eight data bits and that lane's inversion flag into a running checksum. When the burst ends, the lane's checksum is sent one bit per cycle on that lane's serial check pin. Sending starts after a latency that is set separately for reads and writes.

When no checksum is being sent, every check pin repeats a short programmable pattern. The pattern keeps transitions on the pin so that the far end's clock-data recovery stays locked. Checking can be turned off separately for reads and for writes. A burst of a disabled type produces no checksum, and the pins keep the pattern.

Top module: `edc_crc_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, all four bits of `edc_out` are 0.
- R2: When no checksum is being sent, every lane drives `hold_pat[3]`, `hold_pat[2]`, `hold_pat[1]`, `hold_pat[0]` in turn, then repeats. The phase advances every cycle from reset, whatever the traffic. The output in cycle k uses bit `3 - (k mod 4)` of the `hold_pat` value sampled at the preceding clock edge.
- R3: Each lane's checksum uses the generator x^8 + x^2 + x + 1 (0x07) and starts from 0. It covers 72 bits taken beat by beat. Within a beat the order is data bit 7 down to bit 0, then the inversion flag. Lane n uses `beat_data[8n+7:8n]` and `beat_inv[n]`.
- R4: A checksum is sent most significant bit first, over 8 consecutive cycles, on all four lanes at once.
- R5: For a read burst whose last beat is in cycle t, the first checksum bit appears in cycle t+L, where L is `rd_lat`. Values of `rd_lat` below 2 act as 2.
- R6: For a write burst, L is `wr_lat` in the range 8 to 14. Values below 8 act as 8 and values above 14 act as 14.
- R7: A burst is 8 cycles with `beat_valid` high, and cycles without it may fall in between. The burst type is taken from `beat_is_write` on its first beat and is held for the rest of the burst.
- R8: `rd_edc_en` and `wr_edc_en`, sampled on the last beat, decide whether a burst of that type sends a checksum. A disabled burst leaves the pins on the hold pattern.
- R9: Several checksums may be pending at once. Bursts sent back to back with the same latency produce checksum windows that follow each other with no hold cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | A data beat is present this cycle |
| beat_is_write | input | 1 | Burst type, 1 = write; taken on the first beat |
| beat_data | input | 32 | Beat data, four byte lanes |
| beat_inv | input | 4 | Per-lane inversion flag for this beat |
| rd_edc_en | input | 1 | Send checksums for reads |
| wr_edc_en | input | 1 | Send checksums for writes |
| rd_lat | input | 2 | Read checksum latency in cycles |
| wr_lat | input | 4 | Write checksum latency in cycles |
| hold_pat | input | 4 | Idle pattern, sent bit 3 first |
| edc_out | output | 4 | Serial check pin per byte lane |

## Verification
Bursts are drawn from several seeds so that the lanes carry different data and inversion flags. One all-zero burst gives a checksum of 0, which separates a silent window from the hold pattern. Reads run at both latencies and at a clamped setting, and writes run at the bounds, in the middle of the range and at both clamped settings. A latency that is off by one cycle therefore shows up as a shifted bit stream. Separate runs cover a burst with a gap and a type flip after its first beat, bursts with checking disabled, and back-to-back pairs that leave two checksums pending at once. The hold pattern is changed several times while idle so that errors in phase and bit order show.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // One serial step of the checksum register, input bit b.
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/edc_lane_crc.sv
module edc_lane_crc #(
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_en,
  input  logic                      first,
  input  logic [LANE_W-1:0]         d,
  input  logic                      inv,
  output logic [edc_pkg::CRC_W-1:0] crc_nxt
);
  import edc_pkg::*;

  logic [CRC_W-1:0] crc_q;

  // Data bits high to low, then the inversion flag (R3)
  always_comb begin
    logic [CRC_W-1:0] c;
    c = first ? '0 : crc_q;
    for (int i = LANE_W - 1; i >= 0; i--) c = crc_bit(c, d[i]);
    c = crc_bit(c, inv);
    crc_nxt = c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (beat_en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/edc_delay_line.sv
module edc_delay_line #(
  parameter int DEPTH  = 13,
  parameter int W      = 32,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_vld,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [W-1:0]      ins_data,
  output logic              head_vld,
  output logic [W-1:0]      head_data
);
  logic [DEPTH-1:0] vld_q, vld_n;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_n [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      vld_n[k] = vld_q[k+1];
      dat_n[k] = dat_q[k+1];
    end
    vld_n[DEPTH-1] = 1'b0;
    dat_n[DEPTH-1] = dat_q[DEPTH-1];
    if (ins_vld) begin
      vld_n[ins_slot] = 1'b1;
      dat_n[ins_slot] = ins_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < DEPTH; k++) dat_q[k] <= '0;
    end else begin
      vld_q <= vld_n;
      for (int k = 0; k < DEPTH; k++) dat_q[k] <= dat_n[k];
    end
  end

  assign head_vld  = vld_q[0];
  assign head_data = dat_q[0];
endmodule

// File: rtl/edc_serializer.sv
module edc_serializer #(
  parameter int LANES  = 4,
  parameter int CRC_W  = 8,
  parameter int HOLD_W = 4,
  localparam int CNT_W = $clog2(CRC_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LANES*CRC_W-1:0] load_data,
  input  logic [HOLD_W-1:0]      hold_pat,
  output logic [LANES-1:0]       edc_out,
  output logic                   busy,
  output logic [CNT_W-1:0]       bit_cnt
);
  localparam int PH_W = $clog2(HOLD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CRC_W - 1);

  logic [PH_W-1:0]  ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic [LANES-1:0] out_q, out_n;
  logic [CRC_W-1:0] sh_q [LANES];
  logic [CRC_W-1:0] sh_n [LANES];

  always_comb begin
    ph_n   = ph_q + 1'b1;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    out_n  = out_q;
    for (int l = 0; l < LANES; l++) sh_n[l] = sh_q[l];
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      for (int l = 0; l < LANES; l++) begin
        out_n[l] = load_data[l*CRC_W + CRC_W - 1];
        sh_n[l]  = {load_data[l*CRC_W +: CRC_W-1], 1'b0};
      end
    end else if (busy_q && cnt_q != LAST_BIT) begin
      cnt_n = cnt_q + 1'b1;
      for (int l = 0; l < LANES; l++) begin
        out_n[l] = sh_q[l][CRC_W-1];
        sh_n[l]  = {sh_q[l][CRC_W-2:0], 1'b0};
      end
    end else begin
      busy_n = 1'b0;
      cnt_n  = '0;
      out_n  = {LANES{hold_pat[~ph_n]}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      out_q  <= '0;
      for (int l = 0; l < LANES; l++) sh_q[l] <= '0;
    end else begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      out_q  <= out_n;
      for (int l = 0; l < LANES; l++) sh_q[l] <= sh_n[l];
    end
  end

  assign edc_out = out_q;
  assign busy    = busy_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/edc_crc_unit.sv
module edc_crc_unit #(
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int BEATS      = 8,
  parameter int RD_LAT_MIN = 2,
  parameter int RD_LAT_MAX = 3,
  parameter int WR_LAT_MIN = 8,
  parameter int WR_LAT_MAX = 14,
  parameter int HOLD_W     = 4,
  localparam int DATA_W    = LANES * LANE_W,
  localparam int RL_W      = $clog2(RD_LAT_MAX + 1),
  localparam int WL_W      = $clog2(WR_LAT_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_is_write,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [LANES-1:0]  beat_inv,
  input  logic              rd_edc_en,
  input  logic              wr_edc_en,
  input  logic [RL_W-1:0]   rd_lat,
  input  logic [WL_W-1:0]   wr_lat,
  input  logic [HOLD_W-1:0] hold_pat,
  output logic [LANES-1:0]  edc_out
);
  import edc_pkg::*;

  localparam int BEAT_CW     = $clog2(BEATS);
  localparam int PIPE_STAGES = 2;
  localparam int DL_DEPTH    = WR_LAT_MAX - PIPE_STAGES + 1;
  localparam int SLOT_W      = $clog2(DL_DEPTH);
  localparam int CNT_W       = $clog2(CRC_W);
  localparam logic [WL_W-1:0]    RD_MIN_V  = WL_W'(RD_LAT_MIN);
  localparam logic [WL_W-1:0]    RD_MAX_V  = WL_W'(RD_LAT_MAX);
  localparam logic [WL_W-1:0]    WR_MIN_V  = WL_W'(WR_LAT_MIN);
  localparam logic [WL_W-1:0]    WR_MAX_V  = WL_W'(WR_LAT_MAX);
  localparam logic [WL_W-1:0]    LAT_BASE  = WL_W'(PIPE_STAGES);
  localparam logic [BEAT_CW-1:0] LAST_BEAT = BEAT_CW'(BEATS - 1);

  // Burst framing
  logic [BEAT_CW-1:0] beat_q, beat_n;
  logic               typ_q;
  logic               first, last, cur_wr, ins;
  logic [WL_W-1:0]    rd_w, lat;
  logic [SLOT_W-1:0]  slot;
  logic [LANES*CRC_W-1:0] crc_all, head_data;
  logic               head_vld;
  logic               ser_busy;
  logic [CNT_W-1:0]   ser_cnt;

  assign first  = (beat_q == '0);
  assign last   = (beat_q == LAST_BEAT);
  assign cur_wr = first ? beat_is_write : typ_q;
  assign beat_n = last ? '0 : beat_q + 1'b1;
  assign ins    = beat_valid && last && (cur_wr ? wr_edc_en : rd_edc_en);
  assign rd_w   = WL_W'(rd_lat);

  always_comb begin
    if (cur_wr)
      lat = (wr_lat < WR_MIN_V) ? WR_MIN_V : (wr_lat > WR_MAX_V) ? WR_MAX_V : wr_lat;
    else
      lat = (rd_w < RD_MIN_V) ? RD_MIN_V : (rd_w > RD_MAX_V) ? RD_MAX_V : rd_w;
    slot = SLOT_W'(lat - LAT_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      typ_q  <= 1'b0;
    end else if (beat_valid) begin
      beat_q <= beat_n;
      if (first) typ_q <= beat_is_write;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edc_lane_crc #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_en (beat_valid),
      .first   (first),
      .d       (beat_data[g*LANE_W +: LANE_W]),
      .inv     (beat_inv[g]),
      .crc_nxt (crc_all[g*CRC_W +: CRC_W])
    );
  end

  edc_delay_line #(.DEPTH(DL_DEPTH), .W(LANES*CRC_W), .SLOT_W(SLOT_W)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_vld   (ins),
    .ins_slot  (slot),
    .ins_data  (crc_all),
    .head_vld  (head_vld),
    .head_data (head_data)
  );

  edc_serializer #(.LANES(LANES), .CRC_W(CRC_W), .HOLD_W(HOLD_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (head_vld),
    .load_data (head_data),
    .hold_pat  (hold_pat),
    .edc_out   (edc_out),
    .busy      (ser_busy),
    .bit_cnt   (ser_cnt)
  );
endmodule

// File: rtl/edc_crc_unit_chk.sv
module edc_crc_unit_chk #(
  parameter int LANES  = 4,
  parameter int BEATS  = 8,
  parameter int HOLD_W = 4,
  parameter int RL_W   = 2,
  parameter int WL_W   = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic              beat_is_write,
  input logic              rd_edc_en,
  input logic              wr_edc_en,
  input logic [RL_W-1:0]   rd_lat,
  input logic [WL_W-1:0]   wr_lat,
  input logic [HOLD_W-1:0] hold_pat,
  input logic [LANES-1:0]  edc_out,
  input logic              ser_busy,
  input logic [CNT_W-1:0]  ser_cnt
);
  localparam int BC_W = $clog2(BEATS);
  localparam int PH_W = $clog2(HOLD_W);

  logic [BC_W-1:0]   bc;
  logic              typ_q, started;
  logic [PH_W-1:0]   ph;
  logic [HOLD_W-1:0] hold_q;
  logic [2:0]        run;
  logic              lastc, typc;

  assign lastc = beat_valid && (bc == BC_W'(BEATS - 1));
  assign typc  = (bc == '0) ? beat_is_write : typ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc <= '0; typ_q <= 1'b0; started <= 1'b0; ph <= '0; hold_q <= '0; run <= '0;
    end else begin
      if (beat_valid) begin
        bc <= bc + 1'b1;
        if (bc == '0) typ_q <= beat_is_write;
      end
      started <= 1'b1;
      ph      <= ph + 1'b1;
      hold_q  <= hold_pat;
      run     <= ser_busy ? run + 1'b1 : 3'd0;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !ser_busy) |-> (edc_out == {LANES{hold_q[~ph]}})); // R2

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_busy) |-> (run == 3'd0)); // R4

  AST_RD_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (lastc && !typc && rd_edc_en && rd_lat != RL_W'(3)) |=> ##1 (ser_busy && ser_cnt == '0)); // R5

  AST_RD_LAT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (lastc && !typc && rd_edc_en && rd_lat == RL_W'(3)) |=> ##2 (ser_busy && ser_cnt == '0)); // R5

  AST_WR_LAT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (lastc && typc && wr_edc_en && wr_lat <= WL_W'(8)) |=> ##7 (ser_busy && ser_cnt == '0)); // R6

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (edc_out == '0)); // R1
endmodule

bind edc_crc_unit edc_crc_unit_chk #(
  .LANES(LANES), .BEATS(BEATS), .HOLD_W(HOLD_W), .RL_W(RL_W), .WL_W(WL_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .beat_valid    (beat_valid),
  .beat_is_write (beat_is_write),
  .rd_edc_en     (rd_edc_en),
  .wr_edc_en     (wr_edc_en),
  .rd_lat        (rd_lat),
  .wr_lat        (wr_lat),
  .hold_pat      (hold_pat),
  .edc_out       (edc_out),
  .ser_busy      (ser_busy),
  .ser_cnt       (ser_cnt)
);

// File: tb/edc_crc_unit_bench.sv
module edc_crc_unit_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        beat_valid, beat_is_write, rd_edc_en, wr_edc_en;
  logic [31:0] beat_data;
  logic [3:0]  beat_inv, wr_lat, hold_pat;
  logic [1:0]  rd_lat;
  logic [3:0]  edc_out;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string idle_tag = "R2";
  logic [3:0] exp_bits [int];
  string      exp_tag  [int];
  logic [31:0] bd [8];
  logic [3:0]  bi [8];

  always #2.5 clk = ~clk;

  edc_crc_unit u_edc_crc_unit (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_is_write(beat_is_write),
    .beat_data(beat_data), .beat_inv(beat_inv), .rd_edc_en(rd_edc_en), .wr_edc_en(wr_edc_en),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .hold_pat(hold_pat), .edc_out(edc_out)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: edc_out=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  // Advance one cycle and compare the pins with the model
  task automatic tick();
    logic [3:0] e;
    string t;
    @(negedge clk);
    cyc++;
    if (exp_bits.exists(cyc)) begin
      e = exp_bits[cyc];
      t = exp_tag[cyc];
    end else begin
      e = {4{hold_pat[3 - (cyc % 4)]}};
      t = idle_tag;
    end
    check(edc_out, e, t);
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  // Behavioural checksum: generator 0x07, zero start, 9 bits per beat
  function automatic logic [7:0] model_crc(input int lane);
    int c = 0;
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 9; k++) begin
        int bitv = (k < 8) ? int'(bd[b][lane*8 + 7 - k]) : int'(bi[b][lane]);
        int fb   = ((c >> 7) & 1) ^ bitv;
        c = ((c << 1) & 255) ^ (fb != 0 ? 7 : 0);
      end
    end
    return 8'(c);
  endfunction

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic burst(input bit wr, input int seed, input string tag, input bit flip, input bit gap);
    logic [7:0] crc [4];
    int lat;
    bit en;
    for (int b = 0; b < 8; b++) begin
      if (gap && b == 3) begin
        beat_valid = 1'b0;
        tick();
      end
      bd[b] = (seed == 0) ? 32'h0 : (32'(seed) * 32'h01000193) ^ (32'(b) * 32'h9E3779B9 + 32'(seed));
      bi[b] = (seed == 0) ? 4'h0 : 4'(seed * 3 + b * 5);
      beat_valid    = 1'b1;
      beat_data     = bd[b];
      beat_inv      = bi[b];
      beat_is_write = (flip && b > 0) ? !wr : wr;
      if (b == 7) begin
        en  = wr ? wr_edc_en : rd_edc_en;
        lat = wr ? clampi(int'(wr_lat), 8, 14) : clampi(int'(rd_lat), 2, 3);
        if (en) begin
          for (int l = 0; l < 4; l++) crc[l] = model_crc(l);
          for (int i = 0; i < 8; i++) begin
            exp_bits[cyc + lat + i] = {crc[3][7-i], crc[2][7-i], crc[1][7-i], crc[0][7-i]};
            exp_tag[cyc + lat + i]  = tag;
          end
        end
      end
      tick();
    end
    beat_valid    = 1'b0;
    beat_is_write = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; beat_valid = 1'b0; beat_is_write = 1'b0; beat_data = '0; beat_inv = '0;
    rd_edc_en = 1'b1; wr_edc_en = 1'b1; rd_lat = 2'd2; wr_lat = 4'd8; hold_pat = 4'b1011;
    repeat (3) @(negedge clk);
    check(edc_out, 4'b0000, "R1");            // R1 during reset
    rst_n = 1'b1;
    check(edc_out, 4'b0000, "R1");            // R1 first cycle after release
    // R2 idle pattern, changed on the fly
    idle(12);
    hold_pat = 4'b0110; idle(8);
    hold_pat = 4'b0001; idle(8);
    hold_pat = 4'b1100;
    // R3 checksum contents, R4 serial order with all-zero data
    burst(1'b0, 1, "R3", 1'b0, 1'b0); idle(24);
    burst(1'b0, 0, "R4", 1'b0, 1'b0); idle(24);
    burst(1'b0, 9, "R4", 1'b0, 1'b0); idle(24);
    // R5 read latency and clamping
    rd_lat = 2'd3; burst(1'b0, 2, "R5", 1'b0, 1'b0); idle(24);
    rd_lat = 2'd0; burst(1'b0, 3, "R5", 1'b0, 1'b0); idle(24);
    rd_lat = 2'd1; burst(1'b0, 10, "R5", 1'b0, 1'b0); idle(24);
    // R6 write latency and clamping
    wr_lat = 4'd8;  burst(1'b1, 4, "R6", 1'b0, 1'b0); idle(30);
    wr_lat = 4'd14; burst(1'b1, 5, "R6", 1'b0, 1'b0); idle(30);
    wr_lat = 4'd11; burst(1'b1, 6, "R6", 1'b0, 1'b0); idle(30);
    wr_lat = 4'd3;  burst(1'b1, 7, "R6", 1'b0, 1'b0); idle(30);
    wr_lat = 4'd15; burst(1'b1, 8, "R6", 1'b0, 1'b0); idle(30);
    // R7 gap inside a burst and a type flip after the first beat
    rd_edc_en = 1'b0; wr_lat = 4'd8;
    burst(1'b1, 11, "R7", 1'b1, 1'b1); idle(30);
    rd_edc_en = 1'b1; rd_lat = 2'd2;
    burst(1'b0, 12, "R7", 1'b1, 1'b1); idle(30);
    // R8 disabled types keep the hold pattern
    idle_tag = "R8";
    rd_edc_en = 1'b0; burst(1'b0, 13, "R8", 1'b0, 1'b0); idle(24);
    rd_edc_en = 1'b1; wr_edc_en = 1'b0; burst(1'b1, 14, "R8", 1'b0, 1'b0); idle(30);
    wr_edc_en = 1'b1;
    idle_tag = "R2";
    // R9 back-to-back bursts with several checksums pending
    rd_lat = 2'd2;
    burst(1'b0, 15, "R9", 1'b0, 1'b0); burst(1'b0, 16, "R9", 1'b0, 1'b0); idle(24);
    wr_lat = 4'd14;
    burst(1'b1, 17, "R9", 1'b0, 1'b0); burst(1'b1, 18, "R9", 1'b0, 1'b0); idle(36);
    hold_pat = 4'b0101; idle(8);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule